// File: doc/BRIEF.md
# Microcontroller Memory Space Decoder

This block sits between a small CPU core and its memories and decides, for each access, which physical target is meant. Instruction fetches are steered to on-chip or off-chip program memory depending on the address and on a board-level pin that allows on-chip code. Data accesses are steered to lower RAM, upper RAM, the special-register space, on-chip expanded RAM or off-chip data memory. The choice depends on the address, on the addressing mode (direct or indirect) and on whether the access is an external move.

The block also owns two 16-bit data pointers and the bit that picks the active one. All three are reached through a byte-wide special-register port. An external move can take its address from the active pointer or from an 8-bit register value. The result is one registered, one-hot target select and the address to present to that target. Both appear one clock after the request.

Top module: `memspace_router`

## Requirements
- R1: After reset, `tgt_sel` and `tgt_addr` are 0, both pointers are 0x0000, the pointer select bit is 0 and `dptr_active` is 0x0000.
- R2: A fetch (`acc_kind`=0) with `code_int_en`=0 selects off-chip program memory (`tgt_sel` bit 1) at every address, and `tgt_addr` carries the full 16-bit address.
- R3: A fetch with `code_int_en`=1 selects on-chip program memory (bit 0) for 0x0000–0x7FFF and off-chip program memory (bit 1) for 0x8000–0xFFFF, with the full address in `tgt_addr`.
- R4: A direct (`acc_kind`=1) or indirect (`acc_kind`=2) access whose low byte is 0x00–0x7F selects lower RAM (bit 2). The upper address byte is ignored and `tgt_addr` is {0x00, low byte}.
- R5: When the low byte is 0x80–0xFF, an indirect access selects upper RAM (bit 3) and a direct access selects the special-register space (bit 4). `tgt_addr` is {0x00, low byte}.
- R6: An external move (`acc_kind`=3) with `xram_off`=0 selects on-chip expanded RAM (bit 5) with `tgt_addr` = {0x00, low 8 bits of the move address}. With `xram_off`=1 it selects off-chip data memory (bit 6) with the full 16-bit move address.
- R7: An external move with `xmove_via_ptr`=1 uses the active pointer as its move address. With `xmove_via_ptr`=0 the move address is {0x00, low byte of `acc_addr`}. `dptr_active` always shows the active pointer.
- R8: Pointer 0 is reached at special-register addresses 0x82 (low byte) and 0x83 (high byte), and pointer 1 at 0x84 (low) and 0x85 (high). A write updates the byte on the next clock edge, and `sfr_rdata` returns the stored byte.
- R9: Bit 0 of address 0xA2 selects the active pointer (0 for pointer 0, 1 for pointer 1). Writes to bits 7:1 are ignored, and a read of 0xA2 returns {7'b0, select}.
- R10: Reads of any other special-register address return 0x00. Writes to such addresses change no pointer and no select bit.
- R11: Outputs are registered with one cycle of latency. After a cycle with `acc_valid`=1 exactly one `tgt_sel` bit is set. After a cycle with `acc_valid`=0 none is set and `tgt_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_kind | input | 2 | 0 fetch, 1 direct, 2 indirect, 3 external move |
| acc_addr | input | 16 | Access address |
| code_int_en | input | 1 | 1 allows on-chip program memory for low fetch addresses |
| xram_off | input | 1 | 0 sends external moves to on-chip expanded RAM, 1 sends them off-chip |
| xmove_via_ptr | input | 1 | External move takes its address from the active pointer |
| sfr_we | input | 1 | Special-register write strobe |
| sfr_addr | input | 8 | Special-register address for read and write |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Special-register read data (combinational) |
| tgt_sel | output | 7 | Registered one-hot target select |
| tgt_addr | output | 16 | Registered address for the selected target |
| dptr_active | output | 16 | Value of the active data pointer |

## Verification
The bench aims at the address seams: fetches at 0x7FFF and 0x8000 with the pin high and low, and data accesses at 0x7F and 0x80 in both addressing modes. A decoder that compares the wrong bit, or that ignores the mode, would send these to the wrong memory. Nonzero upper bytes on internal data accesses catch a decoder that lets the high byte leak into RAM or special-register selection. A move to expanded RAM through a pointer whose high byte is set catches an address that is not truncated. Writes of 0xFF to the select register catch select bits that are not masked. Writes to unimplemented addresses next to the pointer bytes catch an address decode that is too wide and corrupts a pointer. Writes followed at once by moves through the pointer catch a move that reads a stale or premature pointer value.

// File: rtl/memspace_pkg.sv
package memspace_pkg;

    localparam int AW      = 16;
    localparam int BW      = 8;
    localparam int NTGT    = 7;
    localparam int NPTR    = 2;

    localparam int T_CODE_INT = 0;
    localparam int T_CODE_EXT = 1;
    localparam int T_LRAM     = 2;
    localparam int T_URAM     = 3;
    localparam int T_SFR      = 4;
    localparam int T_XRAM     = 5;
    localparam int T_XDATA    = 6;

    localparam logic [BW-1:0] PTR_BASE = 8'h82;
    localparam logic [BW-1:0] SEL_ADDR = 8'hA2;

    typedef enum logic [1:0] {
        ACC_FETCH    = 2'd0,
        ACC_DIRECT   = 2'd1,
        ACC_INDIRECT = 2'd2,
        ACC_XMOVE    = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [NTGT-1:0] sel;
        logic [AW-1:0]   addr;
    } route_t;

endpackage

// File: rtl/ms_code_dec.sv
module ms_code_dec
    import memspace_pkg::*;
#(
    parameter int INT_CODE_AW = 15
) (
    input  logic [AW-1:0]   addr,
    input  logic            int_en,
    output logic [NTGT-1:0] sel
);
    localparam int HI_W = AW - INT_CODE_AW;

    logic in_window;

    always_comb begin
        in_window = (addr[AW-1:INT_CODE_AW] == HI_W'(0));
        sel = '0;
        if (int_en && in_window) begin
            sel[T_CODE_INT] = 1'b1;
        end else begin
            sel[T_CODE_EXT] = 1'b1;
        end
    end
endmodule

// File: rtl/ms_data_dec.sv
module ms_data_dec
    import memspace_pkg::*;
#(
    parameter int XRAM_AW = 8
) (
    input  acc_kind_e       kind,
    input  logic [AW-1:0]   addr,
    input  logic            xram_off,
    input  logic            via_ptr,
    input  logic [AW-1:0]   ptr_val,
    output logic [NTGT-1:0] sel,
    output logic [AW-1:0]   tgt
);
    logic [AW-1:0] move_addr;
    logic [BW-1:0] lo;

    always_comb begin
        lo        = addr[BW-1:0];
        move_addr = via_ptr ? ptr_val : {{(AW-BW){1'b0}}, lo};
        sel       = '0;
        tgt       = '0;
        unique case (kind)
            ACC_DIRECT: begin
                tgt = {{(AW-BW){1'b0}}, lo};
                if (lo[BW-1]) sel[T_SFR]  = 1'b1;
                else          sel[T_LRAM] = 1'b1;
            end
            ACC_INDIRECT: begin
                tgt = {{(AW-BW){1'b0}}, lo};
                if (lo[BW-1]) sel[T_URAM] = 1'b1;
                else          sel[T_LRAM] = 1'b1;
            end
            ACC_XMOVE: begin
                if (xram_off) begin
                    sel[T_XDATA] = 1'b1;
                    tgt          = move_addr;
                end else begin
                    sel[T_XRAM]  = 1'b1;
                    tgt          = {{(AW-XRAM_AW){1'b0}}, move_addr[XRAM_AW-1:0]};
                end
            end
            default: begin
                sel = '0;
                tgt = '0;
            end
        endcase
    end
endmodule

// File: rtl/ms_ptr_bank.sv
module ms_ptr_bank
    import memspace_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] addr,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    output logic [AW-1:0] active
);
    localparam int SELW  = (NPTR > 1) ? $clog2(NPTR) : 1;
    localparam int NBYTE = AW / BW;

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
        logic [SELW-1:0]         psel;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        logic [BW-1:0] a_byte;
        st_d  = st_q;
        rdata = '0;
        for (int i = 0; i < NPTR; i++) begin
            for (int b = 0; b < NBYTE; b++) begin
                a_byte = PTR_BASE + BW'(NBYTE * i + b);
                if (addr == a_byte) begin
                    rdata = st_q.ptr[i][b*BW +: BW];
                    if (we) st_d.ptr[i][b*BW +: BW] = wdata;
                end
            end
        end
        if (addr == SEL_ADDR) begin
            rdata = {{(BW-SELW){1'b0}}, st_q.psel};
            if (we && (int'(wdata[SELW-1:0]) < NPTR)) st_d.psel = wdata[SELW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.ptr[st_q.psel];

    logic hits_ptr;
    assign hits_ptr = (addr >= PTR_BASE) && (addr < PTR_BASE + BW'(NPTR * NBYTE));

    p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == SEL_ADDR) |=> $stable(st_q.psel));

    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && hits_ptr) |=> $stable(st_q.ptr));

    p_ptr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == PTR_BASE) |=> (st_q.ptr[0][BW-1:0] == $past(wdata)));
endmodule

// File: rtl/memspace_router.sv
module memspace_router
    import memspace_pkg::*;
#(
    parameter int INT_CODE_AW = 15,
    parameter int XRAM_AW     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [1:0]      acc_kind,
    input  logic [AW-1:0]   acc_addr,
    input  logic            code_int_en,
    input  logic            xram_off,
    input  logic            xmove_via_ptr,
    input  logic            sfr_we,
    input  logic [BW-1:0]   sfr_addr,
    input  logic [BW-1:0]   sfr_wdata,
    output logic [BW-1:0]   sfr_rdata,
    output logic [NTGT-1:0] tgt_sel,
    output logic [AW-1:0]   tgt_addr,
    output logic [AW-1:0]   dptr_active
);
    acc_kind_e       kind;
    logic [NTGT-1:0] code_sel, data_sel;
    logic [AW-1:0]   data_tgt;
    route_t          rt_d, rt_q;

    assign kind = acc_kind_e'(acc_kind);

    ms_code_dec #(.INT_CODE_AW(INT_CODE_AW)) u_code (
        .addr   (acc_addr),
        .int_en (code_int_en),
        .sel    (code_sel)
    );

    ms_ptr_bank u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sfr_we),
        .addr   (sfr_addr),
        .wdata  (sfr_wdata),
        .rdata  (sfr_rdata),
        .active (dptr_active)
    );

    ms_data_dec #(.XRAM_AW(XRAM_AW)) u_data (
        .kind     (kind),
        .addr     (acc_addr),
        .xram_off (xram_off),
        .via_ptr  (xmove_via_ptr),
        .ptr_val  (dptr_active),
        .sel      (data_sel),
        .tgt      (data_tgt)
    );

    always_comb begin
        rt_d = '0;
        if (acc_valid) begin
            if (kind == ACC_FETCH) begin
                rt_d.sel  = code_sel;
                rt_d.addr = acc_addr;
            end else begin
                rt_d.sel  = data_sel;
                rt_d.addr = data_tgt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign tgt_sel  = rt_q.sel;
    assign tgt_addr = rt_q.addr;

    p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ($countones(tgt_sel) == 1));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (tgt_sel == '0 && tgt_addr == '0));

    p_pin_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == ACC_FETCH && !code_int_en) |=> tgt_sel[T_CODE_EXT]);

    p_high_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == ACC_FETCH && acc_addr[AW-1]) |=> tgt_sel[T_CODE_EXT]);

    p_lowram_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (kind == ACC_DIRECT || kind == ACC_INDIRECT) && !acc_addr[BW-1])
        |=> tgt_sel[T_LRAM]);

    p_mode_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == ACC_DIRECT && acc_addr[BW-1]) |=> tgt_sel[T_SFR]);

    p_xram_trunc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == ACC_XMOVE && !xram_off)
        |=> (tgt_sel[T_XRAM] && tgt_addr[AW-1:XRAM_AW] == '0));
endmodule

// File: tb/sim_memspace_router.sv
module sim_memspace_router;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, code_int_en, xram_off, xmove_via_ptr, sfr_we;
    logic [1:0]  acc_kind;
    logic [15:0] acc_addr;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;
    logic [6:0]  tgt_sel;
    logic [15:0] tgt_addr, dptr_active;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_ptr [2];
    logic        m_psel;

    always #5 clk = ~clk;

    memspace_router u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .code_int_en(code_int_en), .xram_off(xram_off),
        .xmove_via_ptr(xmove_via_ptr), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .tgt_sel(tgt_sel),
        .tgt_addr(tgt_addr), .dptr_active(dptr_active)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [22:0] exp_route(logic v, logic [1:0] k, logic [15:0] a,
                                              logic pin, logic xoff, logic via,
                                              logic [15:0] p);
        logic [6:0]  s = '0;
        logic [15:0] t = '0;
        logic [15:0] m;
        if (v) begin
            case (k)
                2'd0: begin t = a; if (pin && a < 16'h8000) s[0] = 1; else s[1] = 1; end
                2'd1: begin t = {8'h00, a[7:0]}; if (a[7]) s[4] = 1; else s[2] = 1; end
                2'd2: begin t = {8'h00, a[7:0]}; if (a[7]) s[3] = 1; else s[2] = 1; end
                default: begin
                    m = via ? p : {8'h00, a[7:0]};
                    if (xoff) begin s[6] = 1; t = m; end
                    else begin s[5] = 1; t = {8'h00, m[7:0]}; end
                end
            endcase
        end
        return {s, t};
    endfunction

    function automatic string route_tag(logic v, logic [1:0] k, logic [15:0] a,
                                        logic pin, logic via);
        if (!v) return "R11 idle";
        case (k)
            2'd0: return pin ? "R3 fetch" : "R2 fetch";
            2'd3: return via ? "R7 move" : "R6 move";
            default: return a[7] ? "R5 data" : "R4 data";
        endcase
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        case (a)
            8'h82: return m_ptr[0][7:0];
            8'h83: return m_ptr[0][15:8];
            8'h84: return m_ptr[1][7:0];
            8'h85: return m_ptr[1][15:8];
            8'hA2: return {7'b0, m_psel};
            default: return 8'h00;
        endcase
    endfunction

    task automatic step(logic v, logic [1:0] k, logic [15:0] a, logic pin, logic xoff,
                        logic via, logic we, logic [7:0] sa, logic [7:0] sd);
        logic [22:0] e;
        string rtag;
        acc_valid = v; acc_kind = k; acc_addr = a; code_int_en = pin;
        xram_off = xoff; xmove_via_ptr = via; sfr_we = we; sfr_addr = sa; sfr_wdata = sd;
        e = exp_route(v, k, a, pin, xoff, via, m_ptr[m_psel]);
        rtag = route_tag(v, k, a, pin, via);
        @(posedge clk); #1;
        check({rtag, " sel"}, {25'd0, tgt_sel}, {25'd0, e[22:16]});
        check({rtag, " addr"}, {16'd0, tgt_addr}, {16'd0, e[15:0]});
        check("R11 onehot", {31'd0, $countones(tgt_sel) == (v ? 1 : 0)}, 32'd1);
        if (we) begin
            case (sa)
                8'h82: m_ptr[0][7:0]  = sd;
                8'h83: m_ptr[0][15:8] = sd;
                8'h84: m_ptr[1][7:0]  = sd;
                8'h85: m_ptr[1][15:8] = sd;
                8'hA2: m_psel = sd[0];
                default: ;
            endcase
        end
        if (sa == 8'hA2)                   check("R9 read",  {24'd0, sfr_rdata}, {24'd0, exp_read(sa)});
        else if (sa >= 8'h82 && sa <= 8'h85) check("R8 read",  {24'd0, sfr_rdata}, {24'd0, exp_read(sa)});
        else                                check("R10 read", {24'd0, sfr_rdata}, {24'd0, exp_read(sa)});
        check("R7 active", {16'd0, dptr_active}, {16'd0, m_ptr[m_psel]});
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] pick [8];
        void'($urandom(32'd1234));
        pick = '{8'h82, 8'h83, 8'h84, 8'h85, 8'hA2, 8'h81, 8'h86, 8'hA3};
        m_ptr[0] = '0; m_ptr[1] = '0; m_psel = 0;
        rst_n = 0; acc_valid = 0; acc_kind = 0; acc_addr = 0; code_int_en = 0;
        xram_off = 0; xmove_via_ptr = 0; sfr_we = 0; sfr_addr = 8'h82; sfr_wdata = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 sel", {25'd0, tgt_sel}, 32'd0);
        check("R1 addr", {16'd0, tgt_addr}, 32'd0);
        check("R1 ptr", {16'd0, dptr_active}, 32'd0);
        sfr_addr = 8'hA2; #1;
        check("R1 psel", {24'd0, sfr_rdata}, 32'd0);
        rst_n = 1;

        // R2 / R3 fetch seams
        step(1, 0, 16'h7FFF, 1, 0, 0, 0, 8'h00, 0);
        step(1, 0, 16'h8000, 1, 0, 0, 0, 8'h00, 0);
        step(1, 0, 16'h0000, 0, 0, 0, 0, 8'h00, 0);
        step(1, 0, 16'h7FFF, 0, 0, 0, 0, 8'h00, 0);
        // R4 / R5 with nonzero high bytes
        step(1, 1, 16'hAB7F, 0, 0, 0, 0, 8'h00, 0);
        step(1, 2, 16'hCD7F, 0, 0, 0, 0, 8'h00, 0);
        step(1, 1, 16'h1280, 0, 0, 0, 0, 8'h00, 0);
        step(1, 2, 16'hFF80, 0, 0, 0, 0, 8'h00, 0);
        // R8 pointer writes then immediate moves (R6 / R7)
        step(0, 0, 0, 0, 0, 0, 1, 8'h82, 8'h34);
        step(1, 3, 0, 0, 1, 1, 1, 8'h83, 8'h12);
        step(1, 3, 0, 0, 1, 1, 0, 8'h83, 8'h00);
        step(1, 3, 16'h5566, 0, 0, 1, 0, 8'h82, 8'h00);
        step(1, 3, 16'h5566, 0, 0, 0, 0, 8'h82, 8'h00);
        step(1, 3, 16'h5566, 0, 1, 0, 0, 8'h82, 8'h00);
        // R9 masking, R10 neighbours
        step(0, 0, 0, 0, 0, 0, 1, 8'h85, 8'hBE);
        step(0, 0, 0, 0, 0, 0, 1, 8'hA2, 8'hFF);
        step(1, 3, 0, 0, 1, 1, 0, 8'hA2, 8'h00);
        step(0, 0, 0, 0, 0, 0, 1, 8'h81, 8'hEE);
        step(0, 0, 0, 0, 0, 0, 1, 8'h86, 8'hEE);
        step(0, 0, 0, 0, 0, 0, 0, 8'h81, 8'h00);
        step(0, 0, 0, 0, 0, 0, 1, 8'hA2, 8'hFE);
        step(0, 0, 0, 0, 0, 0, 0, 8'hA2, 8'h00);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], 16'($urandom), r[4], r[5], r[6],
                 r[7] & r[8], (r[11:9] == 3'd0) ? 8'($urandom) : pick[r[14:12]],
                 8'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule